// File: doc/BRIEF.md
# Fractional Microsecond Timebase Counter

This block keeps a free-running microsecond count for a chip whose reference clock is not a whole number of megahertz. A rational prescaler advances the count by an average of exactly one per microsecond. Software programs the ratio as a pair of 8-bit fields, each holding its value minus one: how many reference clocks make up one period, and how many microseconds that period is worth. An accumulator adds the microsecond weight on every reference clock. It subtracts the clock weight whenever the sum reaches it. Reference rates such as 12.8, 16.8, 19.2 or 38.4 MHz therefore give a drift-free 1 MHz average.

The count is read over a simple word-addressed register bus. A hold register stops both the count and the fractional remainder. Each advance is also driven out as a one-cycle pulse, so neighbouring timers can use it as a microsecond tick enable. Software derives the ratio from the clock rate and may rewrite it at any time, for example after a low-power exit.

Top module: `usec_timebase`

## Requirements
- R1: After reset the count reads 0, the ratio register reads 0x000B (12 clocks per microsecond), the hold register reads 0 and `us_tick` is low.
- R2: The ratio register sits at offset 0x14. Bits 7:0 hold (reference clocks per period − 1) and bits 15:8 hold (microseconds per period − 1). A write stores bits 15:0, and a read returns them with bits 31:16 zero.
- R3: After a ratio write with microseconds ≤ clocks, the count advances by exactly floor(N·(hi+1)/(lo+1)) over the N clock edges that follow the write edge.
- R4: With bits 15:8 zero the block is an integer divider: one advance every (lo+1) clocks.
- R5: When (hi+1) exceeds (lo+1), the count advances on every clock edge.
- R6: The hold register sits at offset 0x4C, and only bit 0 is stored. While it reads 1, the count and the fractional remainder keep their values. The edge that writes 1 still counts; the edge that writes 0 does not. After resuming, the total advance equals the R3 formula applied to the active edges only.
- R7: A ratio write clears the fractional remainder, and its own edge produces no advance.
- R8: The count sits at offset 0x10 and is read-only: writes to it, and writes to unmapped offsets, change nothing, and reads of unmapped offsets return 0.
- R9: `us_tick` is high for exactly the one cycle after each edge at which the count advanced, so the number of pulses equals the number of advances.
- R10: The count wraps modulo 2^CNT_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, one write per cycle it is high |
| bus_addr | input | ADDR_W (8) | Byte offset of the register |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for `bus_addr`, combinational |
| us_tick | output | 1 | One-cycle pulse after each count advance |

## Verification
The bench goes after the edges where a design can be off by one advance. It checks that the ratio-write edge is dead and that the remainder is cleared: leaving the remainder in place gives one extra advance in a short window after the write. It checks that the edge writing hold still counts while the edge clearing it does not, and that the remainder survives a hold; a design that dropped or restarted the remainder would miss the expected total over the active edges. Random ratios with long windows expose any rounding or remainder drift, an inverted field order would give the wrong rate, and a narrow second instance shows whether wrap-around is handled or saturates.

// File: rtl/utb_pkg.sv
package utb_pkg;
   localparam int UTB_ADDR_W = 8;
   localparam int UTB_DATA_W = 32;
   localparam int UTB_FLD_W  = 8;

   // register offsets; software depends on these positions
   localparam logic [UTB_ADDR_W-1:0] OFS_COUNT = 8'h10;
   localparam logic [UTB_ADDR_W-1:0] OFS_RATIO = 8'h14;
   localparam logic [UTB_ADDR_W-1:0] OFS_HOLD  = 8'h4C;

   typedef enum logic [1:0] {
      SEL_NONE  = 2'd0,
      SEL_COUNT = 2'd1,
      SEL_RATIO = 2'd2,
      SEL_HOLD  = 2'd3
   } utb_sel_e;
endpackage

// File: rtl/utb_regs.sv
module utb_regs
   import utb_pkg::*;
#(
   parameter int ADDR_W  = UTB_ADDR_W,
   parameter int DATA_W  = UTB_DATA_W,
   parameter int FLD_W   = UTB_FLD_W,
   parameter logic [2*FLD_W-1:0] RST_CFG = 16'h000B
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic [DATA_W-1:0] count_val,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [FLD_W-1:0]  num_m1,
   output logic [FLD_W-1:0]  den_m1,
   output logic              hold,
   output logic              restart
);
   localparam int CFG_W = 2 * FLD_W;

   if (CFG_W > DATA_W) begin : g_chk_cfg
      $error("utb_regs: ratio fields wider than the data bus");
   end

   utb_sel_e         sel;
   logic [CFG_W-1:0] cfg_q;
   logic             hold_q;

   always_comb begin
      unique case (bus_addr)
         ADDR_W'(OFS_COUNT): sel = SEL_COUNT;
         ADDR_W'(OFS_RATIO): sel = SEL_RATIO;
         ADDR_W'(OFS_HOLD):  sel = SEL_HOLD;
         default:            sel = SEL_NONE;
      endcase
   end

   assign restart = bus_we && (sel == SEL_RATIO);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q  <= RST_CFG;
         hold_q <= 1'b0;
      end else if (bus_we) begin
         if (sel == SEL_RATIO) cfg_q  <= bus_wdata[CFG_W-1:0];
         if (sel == SEL_HOLD)  hold_q <= bus_wdata[0];
      end
   end

   assign num_m1 = cfg_q[CFG_W-1:FLD_W];
   assign den_m1 = cfg_q[FLD_W-1:0];
   assign hold   = hold_q;

   always_comb begin
      bus_rdata = '0;
      unique case (sel)
         SEL_COUNT: bus_rdata = count_val;
         SEL_RATIO: bus_rdata[CFG_W-1:0] = cfg_q;
         SEL_HOLD:  bus_rdata[0] = hold_q;
         default:   bus_rdata = '0;
      endcase
   end

   AST_RATIO_STORED: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> ({num_m1, den_m1} == $past(bus_wdata[CFG_W-1:0]))); // R2
   AST_HOLD_STORED: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == ADDR_W'(OFS_HOLD)) |=> (hold == $past(bus_wdata[0]))); // R6
endmodule

// File: rtl/utb_prescaler.sv
module utb_prescaler
   import utb_pkg::*;
#(
   parameter int FLD_W = UTB_FLD_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [FLD_W-1:0] num_m1,
   input  logic [FLD_W-1:0] den_m1,
   input  logic             hold,
   input  logic             restart,
   output logic             step,
   output logic             tick_q
);
   localparam int SUM_W = FLD_W + 2;

   logic [FLD_W-1:0] acc_q, acc_d;
   logic [SUM_W-1:0] sum, den, rem;

   always_comb begin
      sum   = SUM_W'(acc_q) + SUM_W'(num_m1) + SUM_W'(1);
      den   = SUM_W'(den_m1) + SUM_W'(1);
      rem   = sum - den;
      step  = 1'b0;
      acc_d = acc_q;
      if (restart) begin
         acc_d = '0;
      end else if (!hold) begin
         if (sum >= den) begin
            step  = 1'b1;
            // more than one microsecond per clock: clamp, advance every edge
            acc_d = (rem > SUM_W'(den_m1)) ? den_m1 : rem[FLD_W-1:0];
         end else begin
            acc_d = sum[FLD_W-1:0];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q  <= '0;
         tick_q <= 1'b0;
      end else begin
         acc_q  <= acc_d;
         tick_q <= step;
      end
   end

   AST_REM_BELOW_DEN: assert property (@(posedge clk) disable iff (!rst_n)
      acc_q <= den_m1); // R3
   AST_HOLD_KEEPS_REM: assert property (@(posedge clk) disable iff (!rst_n)
      (hold && !restart) |=> $stable(acc_q)); // R6
   AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (acc_q == '0)); // R7
   AST_RESTART_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> !tick_q); // R7
endmodule

// File: rtl/utb_counter.sv
module utb_counter #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   output logic [CNT_W-1:0] cnt
);
   if (CNT_W < 2) begin : g_chk_w
      $error("utb_counter: CNT_W must be at least 2");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt_q <= '0;
      else if (inc) cnt_q <= cnt_q + CNT_W'(1);
   end

   assign cnt = cnt_q;

   AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !inc |=> $stable(cnt_q)); // R6
   AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && cnt_q == {CNT_W{1'b1}}) |=> (cnt_q == '0)); // R10
endmodule

// File: rtl/usec_timebase.sv
module usec_timebase
   import utb_pkg::*;
#(
   parameter int ADDR_W = UTB_ADDR_W,
   parameter int DATA_W = UTB_DATA_W,
   parameter int FLD_W  = UTB_FLD_W,
   parameter int CNT_W  = 32,
   parameter logic [2*FLD_W-1:0] RST_CFG = 16'h000B
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              us_tick
);
   if (CNT_W > DATA_W) begin : g_chk_cnt
      $error("usec_timebase: count wider than the data bus");
   end

   logic [FLD_W-1:0]  num_m1, den_m1;
   logic              hold, restart, step;
   logic [CNT_W-1:0]  cnt;
   logic [DATA_W-1:0] count_val;

   if (CNT_W == DATA_W) begin : g_cnt_full
      assign count_val = cnt;
   end else begin : g_cnt_pad
      assign count_val = {{(DATA_W-CNT_W){1'b0}}, cnt};
   end

   utb_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FLD_W(FLD_W), .RST_CFG(RST_CFG)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .count_val(count_val), .bus_rdata(bus_rdata),
      .num_m1(num_m1), .den_m1(den_m1), .hold(hold), .restart(restart)
   );

   utb_prescaler #(.FLD_W(FLD_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .num_m1(num_m1), .den_m1(den_m1),
      .hold(hold), .restart(restart), .step(step), .tick_q(us_tick)
   );

   utb_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .inc(step), .cnt(cnt)
   );

   AST_TICK_MATCHES_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      step |=> (us_tick && cnt == $past(cnt) + CNT_W'(1))); // R9
   AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> !us_tick); // R6
   AST_FAST_EVERY_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      (num_m1 > den_m1 && !hold && !restart) |=> us_tick); // R5
   AST_RESET_TICK_LOW: assert property (@(posedge clk)
      !rst_n |-> !us_tick); // R1
endmodule

// File: tb/sim_usec_timebase.sv
module sim_usec_timebase;
   import utb_pkg::*;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [7:0]  bus_addr = 8'h00;
   logic [31:0] bus_wdata = '0;
   logic [31:0] rdata0, rdata1;
   logic        tick0, tick1;

   int errors = 0;
   int checks = 0;
   int tick_cnt = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   usec_timebase u0 (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(rdata0), .us_tick(tick0)
   );

   usec_timebase #(.CNT_W(8)) u1 (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(rdata1), .us_tick(tick1)
   );

   always @(negedge clk) if (rst_n && tick0) tick_cnt++;

   function automatic longint exp_adv(int hi, int lo, longint n);
      if (hi > lo) return n;
      return (n * (hi + 1)) / (lo + 1);
   endfunction

   task automatic check(string req, longint act, longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // call at a negedge; leaves time inside the low phase
   task automatic rd(input logic [7:0] a, output logic [31:0] d0, output logic [31:0] d1);
      bus_addr = a;
      #1;
      d0 = rdata0;
      d1 = rdata1;
   endtask

   // call in the low phase; returns at the negedge after the write edge
   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      bus_we = 1'b1;
      bus_addr = a;
      bus_wdata = d;
      @(posedge clk);
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic run(int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   // write a ratio, run n edges, check advance, pulses and narrow copy
   task automatic measure(string req, int hi, int lo, int n);
      logic [31:0] c0, c1, w0, w1;
      int t0;
      rd(OFS_COUNT, c0, w0);
      t0 = tick_cnt;
      wr(OFS_RATIO, {16'h0, hi[7:0], lo[7:0]});
      run(n);
      rd(OFS_COUNT, c1, w1);
      check(req, longint'(c1 - c0), exp_adv(hi, lo, n));
      check({req, "/R9 pulses"}, tick_cnt - t0, exp_adv(hi, lo, n));
      check("R10 narrow copy wraps", w1, {24'h0, c1[7:0]});
   endtask

   initial begin : wdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin : stim
      logic [31:0] a, b, c;
      logic [31:0] seed;
      int t0;
      seed = $urandom(32'd20240611);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(OFS_COUNT, a, b);
      check("R1 count", a, 0);
      check("R1 tick", tick0, 0);
      rd(OFS_RATIO, a, b);
      check("R1 ratio", a, 32'h0000_000B);
      rd(OFS_HOLD, a, b);
      check("R1 hold", a, 0);
      // default ratio: one advance per 12 clocks (R4)
      run(36);
      rd(OFS_COUNT, a, b);
      check("R4 default divide", a, 3);

      // R2 readback, upper bits dropped
      wr(OFS_RATIO, 32'hABCD_045F);
      rd(OFS_RATIO, a, b);
      check("R2 ratio readback", a, 32'h0000_045F);

      // R4 integer divider, R3 fractional settings
      measure("R4 divide by 5", 0, 4, 23);
      measure("R3 12.8MHz", 4, 63, 640);
      measure("R3 19.2MHz", 4, 95, 961);
      measure("R3 38.4MHz", 4, 191, 1919);
      // R5 more microseconds than clocks
      measure("R5 every edge", 2, 1, 17);
      // boundary: lo=0 hi=0, and full-scale fields
      measure("R4 divide by 1", 0, 0, 9);
      measure("R3 full fields", 255, 255, 50);

      // R7 ratio write clears a partial remainder
      wr(OFS_RATIO, 32'h0000_0009);
      run(5);
      measure("R7 remainder cleared", 0, 9, 9);

      // R6 hold: write edge counts, clear edge does not, remainder kept
      rd(OFS_COUNT, a, b);
      wr(OFS_RATIO, 32'h0000_0206);
      run(5);
      wr(OFS_HOLD, 32'hFFFF_FFFF);
      rd(OFS_HOLD, b, c);
      check("R6 hold bit0 only", b, 1);
      rd(OFS_COUNT, b, c);
      t0 = tick_cnt;
      run(20);
      rd(OFS_COUNT, c, seed);
      check("R6 frozen count", c, b);
      check("R6 frozen no pulse", tick_cnt - t0, 0);
      // R8 writes to count and unmapped space ignored
      wr(OFS_COUNT, 32'hDEAD_BEEF);
      wr(8'h20, 32'h0000_1234);
      rd(OFS_COUNT, c, seed);
      check("R8 count write ignored", c, b);
      rd(OFS_RATIO, c, seed);
      check("R8 unmapped write ignored", c, 32'h0000_0206);
      rd(8'h20, c, seed);
      check("R8 unmapped read zero", c, 0);
      wr(OFS_HOLD, 32'h0);
      run(7);
      rd(OFS_COUNT, c, seed);
      check("R6 resume total", longint'(c - a), exp_adv(2, 6, 13));

      // constrained random ratios
      for (int i = 0; i < 10; i++) begin
         int lo, hi, n;
         lo = int'($urandom % 256);
         hi = int'($urandom % (lo + 1));
         if (i == 9) hi = lo + 1 + int'($urandom % (256 - lo - ((lo == 255) ? 1 : 0)));
         if (hi > 255) hi = 255;
         n = 1 + int'($urandom % 2500);
         measure("R3 random ratio", hi, lo, n);
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule